// File: doc/BRIEF.md
# Serial Segment Frame Loader

This block receives display frames for a three-common multiplexed segment driver over a three-wire serial link: a frame-select line, a shift clock and a data line. All three are brought into the fast system clock domain through two-flop synchronizers. Edges are found on the synchronized copies. While the select line is high, every rising shift-clock edge pushes one data bit into a 104-bit sliding window.

When the select line falls, the window is copied in one step into a display latch and three control flags. The window holds 96 display bits, five padding bits and three flag bits. The latch feeds the waveform generator a bit map with one bit per segment and common. Until the next release of the select line, the outputs keep the previous frame.

The control flow is a three-state machine. `LD_IDLE` waits for the select line to rise and moves to `LD_SHIFT` when it does. `LD_SHIFT` accepts clock edges. When the select line falls it moves to `LD_LATCH`. `LD_LATCH` copies the window for one cycle and always returns to `LD_IDLE`.

Top module: `seg_serial_loader`

## Requirements
- R1: While `rst_n` is low, and after it is released with no frame received, `seg_map` is all zero and `half_bias`, `low_power` and `blank` are 0.
- R2: A bit is taken from `sdi_in` only on a rising edge of `sck_in` that occurs while `cs_in` is high. Edges of `sck_in` while `cs_in` is low leave the window unchanged.
- R3: `seg_map` and the flags change only after a falling edge of `cs_in`. During shifting they keep the previously latched frame.
- R4: The first bit sent is D1 and the 96th is D96. For segment n (1..32), D(3n) appears on `seg_map[3(n-1)]` (common 1), D(3n-1) on `seg_map[3(n-1)+1]` (common 2) and D(3n-2) on `seg_map[3(n-1)+2]` (common 3).
- R5: Bits 97 to 101 of a frame are padding. Bit 102 sets `half_bias` (0 selects one-third bias, 1 selects one-half bias), bit 103 sets `low_power` and bit 104 sets `blank`.
- R6: When the latched `blank` is 1, `seg_map` is all zero whatever display bits were sent.
- R7: If the select window holds fewer or more than 104 clocks, the latch takes the last 104 bits shifted in, including bits held over from earlier transfers.
- R8: Frames load the same whether `sck_in` idles low or high between transfers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the shift clock |
| rst_n | input | 1 | Active-low reset, clears all registers |
| cs_in | input | 1 | Frame select, asynchronous; high opens a transfer |
| sck_in | input | 1 | Shift clock, asynchronous; data taken on rising edge |
| sdi_in | input | 1 | Serial data, asynchronous |
| seg_map | output | 96 | Latched display bits, index 3*segment+common, zero while blanked |
| half_bias | output | 1 | Bias select flag: 1 one-half bias, 0 one-third bias |
| low_power | output | 1 | Low-power mode flag |
| blank | output | 1 | Display blanking flag |

## Verification
The bench targets the interleaved order of commons inside a segment. A design that reversed it would show random frames with segment bits rotated between commons. It toggles the shift clock with the select line low and then sends an empty select pulse. A design that shifted on those edges would latch a displaced frame instead of re-latching the old one. Short and long windows show whether held-over bits are kept. Checks taken mid-transfer would catch outputs that update early. Blanked frames with dense display data would expose a blank flag that was not applied to the map.

// File: rtl/seg_loader_pkg.sv
package seg_loader_pkg;

    typedef enum logic [1:0] {
        LD_IDLE  = 2'd0,
        LD_SHIFT = 2'd1,
        LD_LATCH = 2'd2
    } ld_state_e;

endpackage

// File: rtl/seg_sync_edge.sv
module seg_sync_edge #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    always_comb begin
        level = sync_q;
        rise  = sync_q & ~prev_q;
        fall  = ~sync_q & prev_q;
    end

endmodule

// File: rtl/seg_frame_shifter.sv
module seg_frame_shifter #(
    parameter int FRAME_BITS = 104
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  shift_en,
    input  logic                  bit_in,
    output logic [FRAME_BITS-1:0] window
);

    logic [FRAME_BITS-1:0] win_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= '0;
        end else if (shift_en) begin
            win_q <= {win_q[FRAME_BITS-2:0], bit_in};
        end
    end

    assign window = win_q;

endmodule

// File: rtl/seg_frame_latch.sv
module seg_frame_latch #(
    parameter int NUM_SEG   = 32,
    parameter int NUM_COM   = 3,
    parameter int CTRL_BITS = 8
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   load,
    input  logic [NUM_SEG*NUM_COM+CTRL_BITS-1:0]   window,
    output logic [NUM_SEG*NUM_COM-1:0]             seg_map,
    output logic                                   half_bias,
    output logic                                   low_power,
    output logic                                   blank
);

    localparam int DISP_BITS  = NUM_SEG * NUM_COM;
    localparam int FRAME_BITS = DISP_BITS + CTRL_BITS;
    localparam int POS_BLANK  = 0;
    localparam int POS_LOWPWR = 1;
    localparam int POS_BIAS   = 2;

    logic [DISP_BITS-1:0] remap;
    logic [DISP_BITS-1:0] disp_q;
    logic                 bias_q;
    logic                 lowpwr_q;
    logic                 blank_q;

    // Display bit k (1-based, first sent) sits at window[FRAME_BITS-k].
    // Within a segment the commons arrive highest first.
    for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
        for (genvar c = 0; c < NUM_COM; c++) begin : g_com
            localparam int K = s * NUM_COM + (NUM_COM - c);
            assign remap[s*NUM_COM + c] = window[FRAME_BITS - K];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            disp_q   <= '0;
            bias_q   <= 1'b0;
            lowpwr_q <= 1'b0;
            blank_q  <= 1'b0;
        end else if (load) begin
            disp_q   <= remap;
            bias_q   <= window[POS_BIAS];
            lowpwr_q <= window[POS_LOWPWR];
            blank_q  <= window[POS_BLANK];
        end
    end

    always_comb begin
        seg_map   = blank_q ? '0 : disp_q;
        half_bias = bias_q;
        low_power = lowpwr_q;
        blank     = blank_q;
    end

endmodule

// File: rtl/seg_serial_loader.sv
module seg_serial_loader
    import seg_loader_pkg::*;
#(
    parameter int NUM_SEG   = 32,
    parameter int NUM_COM   = 3,
    parameter int CTRL_BITS = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cs_in,
    input  logic                       sck_in,
    input  logic                       sdi_in,
    output logic [NUM_SEG*NUM_COM-1:0] seg_map,
    output logic                       half_bias,
    output logic                       low_power,
    output logic                       blank
);

    localparam int DISP_BITS  = NUM_SEG * NUM_COM;
    localparam int FRAME_BITS = DISP_BITS + CTRL_BITS;
    localparam int IDX_CS     = 2;
    localparam int IDX_SCK    = 1;
    localparam int IDX_SDI    = 0;

    logic [2:0]            lvl;
    logic [2:0]            rise;
    logic [2:0]            fall;
    logic                  cs_lvl;
    logic                  sdi_lvl;
    logic                  cs_rise;
    logic                  cs_fall;
    logic                  sck_rise;
    logic                  shift_en;
    logic                  load;
    logic [FRAME_BITS-1:0] frame_q;
    ld_state_e             state_q;
    ld_state_e             state_d;

    seg_sync_edge #(.WIDTH(3)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({cs_in, sck_in, sdi_in}),
        .level    (lvl),
        .rise     (rise),
        .fall     (fall)
    );

    assign cs_lvl   = lvl[IDX_CS];
    assign sdi_lvl  = lvl[IDX_SDI];
    assign cs_rise  = rise[IDX_CS];
    assign cs_fall  = fall[IDX_CS];
    assign sck_rise = rise[IDX_SCK];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LD_IDLE:  if (cs_rise) state_d = LD_SHIFT;
            LD_SHIFT: if (cs_fall) state_d = LD_LATCH;
            LD_LATCH: state_d = LD_IDLE;
            default:  state_d = LD_IDLE;
        endcase
    end

    // Outputs of the state machine
    always_comb begin
        shift_en = 1'b0;
        load     = 1'b0;
        unique case (state_q)
            LD_IDLE:  ;
            LD_SHIFT: shift_en = sck_rise && cs_lvl;
            LD_LATCH: load = 1'b1;
            default:  ;
        endcase
    end

    seg_frame_shifter #(.FRAME_BITS(FRAME_BITS)) i_shifter (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .bit_in   (sdi_lvl),
        .window   (frame_q)
    );

    seg_frame_latch #(
        .NUM_SEG   (NUM_SEG),
        .NUM_COM   (NUM_COM),
        .CTRL_BITS (CTRL_BITS)
    ) i_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .window    (frame_q),
        .seg_map   (seg_map),
        .half_bias (half_bias),
        .low_power (low_power),
        .blank     (blank)
    );

endmodule

// File: rtl/seg_loader_chk.sv
module seg_loader_chk
    import seg_loader_pkg::*;
#(
    parameter int DISP_BITS  = 96,
    parameter int FRAME_BITS = 104
) (
    input logic                  clk,
    input logic                  rst_n,
    input ld_state_e             state_q,
    input logic                  cs_lvl,
    input logic                  sdi_lvl,
    input logic                  shift_en,
    input logic [FRAME_BITS-1:0] frame_q,
    input logic [DISP_BITS-1:0]  seg_map,
    input logic                  half_bias,
    input logic                  low_power,
    input logic                  blank
);

    assert_window_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_lvl |=> $stable(frame_q));

    assert_outputs_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != LD_LATCH) |=> ($stable(seg_map) && $stable({half_bias, low_power, blank})));

    assert_blank_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        blank |-> (seg_map == '0));

    assert_sliding_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> ((frame_q[0] == $past(sdi_lvl)) &&
                      (frame_q[FRAME_BITS-1:1] == $past(frame_q[FRAME_BITS-2:0]))));

endmodule

bind seg_serial_loader seg_loader_chk #(
    .DISP_BITS  (DISP_BITS),
    .FRAME_BITS (FRAME_BITS)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_q   (state_q),
    .cs_lvl    (cs_lvl),
    .sdi_lvl   (sdi_lvl),
    .shift_en  (shift_en),
    .frame_q   (frame_q),
    .seg_map   (seg_map),
    .half_bias (half_bias),
    .low_power (low_power),
    .blank     (blank)
);

// File: tb/test_seg_serial_loader.sv
`timescale 1ns/1ps
module test_seg_serial_loader;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_in = 1'b0;
    logic        sck_in = 1'b0;
    logic        sdi_in = 1'b0;
    logic [95:0] seg_map;
    logic        half_bias;
    logic        low_power;
    logic        blank;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [103:0] last_frame;

    always #2.5 clk = ~clk;

    seg_serial_loader i_seg_serial_loader (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_in     (cs_in),
        .sck_in    (sck_in),
        .sdi_in    (sdi_in),
        .seg_map   (seg_map),
        .half_bias (half_bias),
        .low_power (low_power),
        .blank     (blank)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [95:0] act, input logic [95:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected map from a 104-bit window whose MSB is the oldest bit (D1).
    function automatic logic [95:0] exp_map(input logic [103:0] v);
        logic [1:96] d;
        logic [95:0] m;
        d = v[103:8];
        for (int s = 0; s < 32; s++) begin
            m[3*s]     = d[3*s+3];
            m[3*s + 1] = d[3*s+2];
            m[3*s + 2] = d[3*s+1];
        end
        if (v[0]) m = '0;
        return m;
    endfunction

    task automatic check_frame(input string req, input logic [103:0] v);
        check(req, seg_map, exp_map(v));
        check(req, {95'd0, half_bias}, {95'd0, v[2]});
        check(req, {95'd0, low_power}, {95'd0, v[1]});
        check(req, {95'd0, blank}, {95'd0, v[0]});
    endtask

    function automatic logic [103:0] make_frame(input logic [1:96] d, input logic bm,
                                                input logic lc, input logic oe);
        return {d, 5'b00000, bm, lc, oe};
    endfunction

    // Sends v[n-1] first down to v[0].
    task automatic shift_bits(input logic [103:0] v, input int n, input bit idle_hi);
        for (int i = n - 1; i >= 0; i--) begin
            sdi_in = v[i];
            sck_in = 1'b0;
            wait_clk(4);
            sck_in = 1'b1;
            wait_clk(4);
        end
        if (!idle_hi) sck_in = 1'b0;
    endtask

    task automatic open_cs();
        cs_in = 1'b1;
        wait_clk(5);
    endtask

    task automatic close_cs();
        wait_clk(5);
        cs_in = 1'b0;
        wait_clk(10);
    endtask

    function automatic logic [1:96] rand_disp();
        logic [1:96] d;
        d = {$urandom(), $urandom(), $urandom()};
        return d;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [103:0] f;
        logic [103:0] g;
        logic [1:96]  d;
        void'($urandom(32'd1234));

        // R1 during and after reset
        wait_clk(3);
        check_frame("R1 in reset", 104'd0);
        rst_n = 1'b1;
        wait_clk(5);
        check_frame("R1 after reset", 104'd0);

        // R4 single-bit walks through interleave corners
        d = '0; d[1] = 1'b1;
        f = make_frame(d, 0, 0, 0);
        open_cs(); shift_bits(f, 104, 0); close_cs();
        check("R4 D1 to seg1 com3", seg_map, 96'd1 << 2);
        d = '0; d[96] = 1'b1;
        f = make_frame(d, 0, 0, 0);
        open_cs(); shift_bits(f, 104, 0); close_cs();
        check("R4 D96 to seg32 com1", seg_map, 96'd1 << 93);
        d = '0; d[5] = 1'b1;
        f = make_frame(d, 1, 0, 0);
        open_cs(); shift_bits(f, 104, 0); close_cs();
        check("R4 D5 to seg2 com2", seg_map, 96'd1 << 4);
        check("R5 bias flag alone", {93'd0, half_bias, low_power, blank}, 96'd4);

        // R5 each flag alone
        f = make_frame('1, 0, 1, 0);
        open_cs(); shift_bits(f, 104, 0); close_cs();
        check_frame("R5 low power flag", f);
        // R6 blank with all display bits set
        f = make_frame('1, 1, 1, 1);
        open_cs(); shift_bits(f, 104, 0); close_cs();
        check("R6 blanked map zero", seg_map, 96'd0);
        check_frame("R6 blanked frame", f);

        // Random frames, with R3 checked mid-transfer
        last_frame = f;
        for (int n = 0; n < 16; n++) begin
            f = make_frame(rand_disp(), 1'($urandom()), 1'($urandom()), 1'(($urandom() % 4) == 0));
            open_cs();
            shift_bits(f >> 52, 52, 0);
            wait_clk(10);
            check_frame("R3 outputs held mid-transfer", last_frame);
            shift_bits(f, 52, 0);
            close_cs();
            check_frame("R4 R5 random frame", f);
            last_frame = f;
        end

        // R2 clocks while select low are ignored
        f = make_frame(rand_disp(), 0, 0, 0);
        open_cs(); shift_bits(f, 104, 0); close_cs();
        for (int i = 0; i < 20; i++) begin
            sdi_in = 1'($urandom());
            sck_in = 1'b1; wait_clk(4);
            sck_in = 1'b0; wait_clk(4);
        end
        open_cs(); close_cs();
        check_frame("R2 empty select after idle clocks", f);

        // R7 long window: junk bits first
        f = make_frame(rand_disp(), 1, 0, 0);
        open_cs(); shift_bits(104'h5, 3, 0); shift_bits(f, 104, 0); close_cs();
        check_frame("R7 long window", f);
        // R7 short window: 8 fresh bits on top of held window
        g = {f[95:0], 8'b1011_0110};
        open_cs(); shift_bits(104'hB6, 8, 0); close_cs();
        check_frame("R7 short window", g);

        // R8 shift clock idles high
        sck_in = 1'b1;
        wait_clk(10);
        f = make_frame(rand_disp(), 0, 1, 0);
        open_cs(); shift_bits(f, 104, 1); close_cs();
        check_frame("R8 idle-high clock", f);
        f = make_frame(rand_disp(), 1, 1, 0);
        open_cs(); shift_bits(f, 104, 1); close_cs();
        check_frame("R8 idle-high clock second", f);

        // R1 reset clears after frames
        rst_n = 1'b0;
        wait_clk(3);
        check_frame("R1 reset after use", 104'd0);
        rst_n = 1'b1;
        wait_clk(3);
        finish_run();
    end

endmodule